// File: doc/BRIEF.md
# Overlay Routing Tile Switch Fabric

This block is the routing slice of one tile in a coarse-grained, island-style compute overlay. Every channel carries two tracks, and each track is a 16-bit word. The slice holds one switch box and two connection boxes. The switch box joins the tracks of crossing channels. Each connection box does two jobs: it picks channel tracks to feed the tile's functional-unit inputs, and it can replace a passing track with the functional unit's result.

All routing selects come from a 20-bit tile configuration word. The word is shifted in one bit per clock and then made active by a separate commit pulse, so the routing never uses a half-loaded word. The switch box is purely combinational. Every connection-box output goes through a register, which adds one cycle of delay.

The array builder places one of these slices next to every functional unit. It chains the configuration inputs and drives the commit for the whole array at once.

Top module: `ovl_route_tile`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge shifts the staging word left by one and places `cfg_bit` in bit 0. A word sent most-significant bit first therefore lands in place after 20 enabled clocks.
- R2: The active routing word changes only on a clock edge where `cfg_commit` is high. Shifting a new word without a commit leaves every routing output unchanged.
- R3: When `cfg_commit` and `cfg_en` are high on the same edge, the active word takes the staging word as it was before that edge's shift.
- R4: Active word layout:
  - bits [2i+1:2i] select switch-box multiplexer i. Multiplexers 0 and 1 drive east tracks 0 and 1. Multiplexers 2 and 3 drive north tracks 0 and 1.
  - bits [13:8] configure the horizontal connection box.
  - bits [19:14] configure the vertical connection box.
- R5: East track t output, with no clock delay, for select 0 to 3: west track t, west track 1-t, south track t, north track t.
- R6: North track t output, with no clock delay, for select 0 to 3: south track t, south track 1-t, west track t, east track t.
- R7: In a connection-box field, bits [1:0] select functional-unit input 0 and bits [3:2] select input 1. The choices for 0 to 3 are: side-a track 0, side-a track 1, side-b track 0, side-b track 1. The result appears one clock after the inputs.
- R8: In a connection-box field, bit 4 (track 0) and bit 5 (track 1) choose the outgoing track. A 1 sends out the functional-unit result; a 0 passes side-a track t through. The result appears one clock after the inputs.
- R9: A synchronous active-high `rst` clears all connection-box registers, the staging word and the active word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration bit |
| cfg_commit | input | 1 | Copies the staging word to the active word |
| sb_w_i | input | 32 | West channel tracks (track t at [16t+15:16t]) |
| sb_s_i | input | 32 | South channel tracks |
| sb_e_i | input | 32 | East channel tracks |
| sb_n_i | input | 32 | North channel tracks |
| sb_e_o | output | 32 | Switch-box drive onto east tracks |
| sb_n_o | output | 32 | Switch-box drive onto north tracks |
| fu_res_i | input | 16 | Functional-unit result word |
| cbh_a_i | input | 32 | Horizontal connection box, side-a tracks |
| cbh_b_i | input | 32 | Horizontal connection box, side-b tracks |
| cbh_fu_o | output | 32 | Registered functional-unit inputs 0 and 1 from the horizontal box |
| cbh_trk_o | output | 32 | Registered outgoing horizontal tracks |
| cbv_a_i | input | 32 | Vertical connection box, side-a tracks |
| cbv_b_i | input | 32 | Vertical connection box, side-b tracks |
| cbv_fu_o | output | 32 | Registered functional-unit inputs 0 and 1 from the vertical box |
| cbv_trk_o | output | 32 | Registered outgoing vertical tracks |

## Verification
Shifting and committing can fall on the same clock edge. The bench first fills the staging word with one pattern without committing it. It then raises the enable and the commit together for a single edge. It judges the result at the routing outputs, which must follow the pre-shift word and not a word moved by one bit. A sweep over 256 configurations drives fresh track words for each one. It also confirms that the switch box responds with no delay and that the connection boxes respond exactly one clock later.

// File: rtl/ort_pkg.sv
package ort_pkg;
    localparam int CHAN_TRK  = 2;
    localparam int SEL_W     = 2;
    localparam int SB_MUXES  = 4;
    localparam int SB_CFG_W  = SB_MUXES * SEL_W;

    typedef struct packed {
        logic             inj1;
        logic             inj0;
        logic [SEL_W-1:0] fu1_sel;
        logic [SEL_W-1:0] fu0_sel;
    } cb_cfg_t;

    localparam int CB_CFG_W = $bits(cb_cfg_t);

    typedef struct packed {
        cb_cfg_t             cbv;
        cb_cfg_t             cbh;
        logic [SB_CFG_W-1:0] sb;
    } tile_cfg_t;

    localparam int TILE_CFG_W = $bits(tile_cfg_t);
endpackage

// File: rtl/ort_cfg_chain.sv
module ort_cfg_chain #(
    parameter int CFG_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_i,
    input  logic             commit,
    output logic [CFG_W-1:0] stage_o,
    output logic [CFG_W-1:0] act_o
);
    typedef struct packed {
        logic [CFG_W-1:0] stage;
        logic [CFG_W-1:0] act;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit)
            st_d.act = st_q.stage;
        if (shift_en)
            st_d.stage = {st_q.stage[CFG_W-2:0], bit_i};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign stage_o = st_q.stage;
    assign act_o   = st_q.act;
endmodule

// File: rtl/ort_switch_box.sv
module ort_switch_box
    import ort_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [CHAN_TRK*W-1:0] w_i,
    input  logic [CHAN_TRK*W-1:0] s_i,
    input  logic [CHAN_TRK*W-1:0] e_i,
    input  logic [CHAN_TRK*W-1:0] n_i,
    input  logic [SB_CFG_W-1:0]   sel_i,
    output logic [CHAN_TRK*W-1:0] e_o,
    output logic [CHAN_TRK*W-1:0] n_o
);
    for (genvar t = 0; t < CHAN_TRK; t++) begin : g_trk
        localparam int TX = CHAN_TRK - 1 - t;
        logic [SEL_W-1:0] sel_e, sel_n;
        logic [W-1:0]     east_d, north_d;

        assign sel_e = sel_i[SEL_W*t +: SEL_W];
        assign sel_n = sel_i[SEL_W*(CHAN_TRK+t) +: SEL_W];

        always_comb begin
            unique case (sel_e)
                2'd0:    east_d = w_i[W*t  +: W];
                2'd1:    east_d = w_i[W*TX +: W];
                2'd2:    east_d = s_i[W*t  +: W];
                default: east_d = n_i[W*t  +: W];
            endcase
            unique case (sel_n)
                2'd0:    north_d = s_i[W*t  +: W];
                2'd1:    north_d = s_i[W*TX +: W];
                2'd2:    north_d = w_i[W*t  +: W];
                default: north_d = e_i[W*t  +: W];
            endcase
        end

        assign e_o[W*t +: W] = east_d;
        assign n_o[W*t +: W] = north_d;
    end
endmodule

// File: rtl/ort_conn_box.sv
module ort_conn_box
    import ort_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  cb_cfg_t               cfg_i,
    input  logic [CHAN_TRK*W-1:0] a_i,
    input  logic [CHAN_TRK*W-1:0] b_i,
    input  logic [W-1:0]          fu_res_i,
    output logic [CHAN_TRK*W-1:0] fu_o,
    output logic [CHAN_TRK*W-1:0] trk_o
);
    localparam int VW = CHAN_TRK * W;

    typedef struct packed {
        logic [VW-1:0] fu;
        logic [VW-1:0] trk;
    } cb_state_t;

    cb_state_t st_d, st_q;

    function automatic logic [W-1:0] pick4(
        input logic [SEL_W-1:0] sel,
        input logic [VW-1:0]    a,
        input logic [VW-1:0]    b
    );
        logic [W-1:0] r;
        unique case (sel)
            2'd0:    r = a[0 +: W];
            2'd1:    r = a[W +: W];
            2'd2:    r = b[0 +: W];
            default: r = b[W +: W];
        endcase
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        st_d.fu[0 +: W]  = pick4(cfg_i.fu0_sel, a_i, b_i);
        st_d.fu[W +: W]  = pick4(cfg_i.fu1_sel, a_i, b_i);
        st_d.trk[0 +: W] = cfg_i.inj0 ? fu_res_i : a_i[0 +: W];
        st_d.trk[W +: W] = cfg_i.inj1 ? fu_res_i : a_i[W +: W];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fu_o  = st_q.fu;
    assign trk_o = st_q.trk;
endmodule

// File: rtl/ovl_route_tile.sv
module ovl_route_tile
    import ort_pkg::*;
#(
    parameter int TRK_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_en,
    input  logic                      cfg_bit,
    input  logic                      cfg_commit,
    input  logic [CHAN_TRK*TRK_W-1:0] sb_w_i,
    input  logic [CHAN_TRK*TRK_W-1:0] sb_s_i,
    input  logic [CHAN_TRK*TRK_W-1:0] sb_e_i,
    input  logic [CHAN_TRK*TRK_W-1:0] sb_n_i,
    output logic [CHAN_TRK*TRK_W-1:0] sb_e_o,
    output logic [CHAN_TRK*TRK_W-1:0] sb_n_o,
    input  logic [TRK_W-1:0]          fu_res_i,
    input  logic [CHAN_TRK*TRK_W-1:0] cbh_a_i,
    input  logic [CHAN_TRK*TRK_W-1:0] cbh_b_i,
    output logic [CHAN_TRK*TRK_W-1:0] cbh_fu_o,
    output logic [CHAN_TRK*TRK_W-1:0] cbh_trk_o,
    input  logic [CHAN_TRK*TRK_W-1:0] cbv_a_i,
    input  logic [CHAN_TRK*TRK_W-1:0] cbv_b_i,
    output logic [CHAN_TRK*TRK_W-1:0] cbv_fu_o,
    output logic [CHAN_TRK*TRK_W-1:0] cbv_trk_o
);
    localparam int VW     = CHAN_TRK * TRK_W;
    localparam int NUM_CB = 2;

    logic [TILE_CFG_W-1:0] stage_w;
    logic [TILE_CFG_W-1:0] act_w;
    tile_cfg_t             act_cfg;

    ort_cfg_chain #(.CFG_W(TILE_CFG_W)) cfg_i (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .bit_i    (cfg_bit),
        .commit   (cfg_commit),
        .stage_o  (stage_w),
        .act_o    (act_w)
    );

    assign act_cfg = tile_cfg_t'(act_w);

    ort_switch_box #(.W(TRK_W)) sb_i (
        .w_i   (sb_w_i),
        .s_i   (sb_s_i),
        .e_i   (sb_e_i),
        .n_i   (sb_n_i),
        .sel_i (act_cfg.sb),
        .e_o   (sb_e_o),
        .n_o   (sb_n_o)
    );

    cb_cfg_t         cb_cfg [NUM_CB];
    logic [VW-1:0]   cb_a   [NUM_CB];
    logic [VW-1:0]   cb_b   [NUM_CB];
    logic [VW-1:0]   cb_fu  [NUM_CB];
    logic [VW-1:0]   cb_trk [NUM_CB];

    assign cb_cfg[0] = act_cfg.cbh;
    assign cb_cfg[1] = act_cfg.cbv;
    assign cb_a[0]   = cbh_a_i;
    assign cb_a[1]   = cbv_a_i;
    assign cb_b[0]   = cbh_b_i;
    assign cb_b[1]   = cbv_b_i;

    for (genvar c = 0; c < NUM_CB; c++) begin : g_cb
        ort_conn_box #(.W(TRK_W)) cb_i (
            .clk      (clk),
            .rst      (rst),
            .cfg_i    (cb_cfg[c]),
            .a_i      (cb_a[c]),
            .b_i      (cb_b[c]),
            .fu_res_i (fu_res_i),
            .fu_o     (cb_fu[c]),
            .trk_o    (cb_trk[c])
        );
    end

    assign cbh_fu_o  = cb_fu[0];
    assign cbh_trk_o = cb_trk[0];
    assign cbv_fu_o  = cb_fu[1];
    assign cbv_trk_o = cb_trk[1];
endmodule

// File: rtl/ort_tile_chk.sv
module ort_tile_chk #(
    parameter int W     = 16,
    parameter int CFG_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_en,
    input logic             cfg_bit,
    input logic             cfg_commit,
    input logic [CFG_W-1:0] stage_w,
    input logic [CFG_W-1:0] act_w,
    input logic [W-1:0]     fu_res_i,
    input logic [2*W-1:0]   cbh_a_i,
    input logic [2*W-1:0]   cbh_fu_o,
    input logic [2*W-1:0]   cbh_trk_o
);
    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> stage_w[0] == $past(cfg_bit));

    // R1
    shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(stage_w));

    // R2
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_commit |=> $stable(act_w));

    // R3
    commit_take_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_commit |=> act_w == $past(stage_w));

    // R8
    inject_chk: assert property (@(posedge clk) disable iff (rst)
        act_w[12] |=> cbh_trk_o[W-1:0] == $past(fu_res_i));

    // R8
    pass_chk: assert property (@(posedge clk) disable iff (rst)
        !act_w[12] |=> cbh_trk_o[W-1:0] == $past(cbh_a_i[W-1:0]));

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (cbh_fu_o == '0 && act_w == '0 && stage_w == '0));
endmodule

bind ovl_route_tile ort_tile_chk #(.W(TRK_W), .CFG_W(ort_pkg::TILE_CFG_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_en     (cfg_en),
    .cfg_bit    (cfg_bit),
    .cfg_commit (cfg_commit),
    .stage_w    (stage_w),
    .act_w      (act_w),
    .fu_res_i   (fu_res_i),
    .cbh_a_i    (cbh_a_i),
    .cbh_fu_o   (cbh_fu_o),
    .cbh_trk_o  (cbh_trk_o)
);

// File: tb/ovl_route_tile_tb.sv
module ovl_route_tile_tb_top;
    localparam int W  = 16;
    localparam int VW = 2 * W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 1'b0, cfg_bit = 1'b0, cfg_commit = 1'b0;
    logic [VW-1:0] sb_w, sb_s, sb_e, sb_n, sb_e_o, sb_n_o;
    logic [W-1:0]  fu_res;
    logic [VW-1:0] cbh_a, cbh_b, cbh_fu, cbh_trk;
    logic [VW-1:0] cbv_a, cbv_b, cbv_fu, cbv_trk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ovl_route_tile #(.TRK_W(W)) dut_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .cfg_commit(cfg_commit),
        .sb_w_i(sb_w), .sb_s_i(sb_s), .sb_e_i(sb_e), .sb_n_i(sb_n),
        .sb_e_o(sb_e_o), .sb_n_o(sb_n_o), .fu_res_i(fu_res),
        .cbh_a_i(cbh_a), .cbh_b_i(cbh_b), .cbh_fu_o(cbh_fu), .cbh_trk_o(cbh_trk),
        .cbv_a_i(cbv_a), .cbv_b_i(cbv_b), .cbv_fu_o(cbv_fu), .cbv_trk_o(cbv_trk)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] trk(input logic [VW-1:0] v, input int t);
        return v[W*t +: W];
    endfunction

    function automatic logic [W-1:0] exp_east(input int t, input int sel);
        case (sel)
            0: return trk(sb_w, t);
            1: return trk(sb_w, 1 - t);
            2: return trk(sb_s, t);
            default: return trk(sb_n, t);
        endcase
    endfunction

    function automatic logic [W-1:0] exp_north(input int t, input int sel);
        case (sel)
            0: return trk(sb_s, t);
            1: return trk(sb_s, 1 - t);
            2: return trk(sb_w, t);
            default: return trk(sb_e, t);
        endcase
    endfunction

    function automatic logic [W-1:0] exp_fu(input logic [VW-1:0] a, input logic [VW-1:0] b, input int sel);
        case (sel)
            0: return trk(a, 0);
            1: return trk(a, 1);
            2: return trk(b, 0);
            default: return trk(b, 1);
        endcase
    endfunction

    task automatic drive_data();
        sb_w = {$urandom, $urandom}; sb_s = {$urandom, $urandom};
        sb_e = {$urandom, $urandom}; sb_n = {$urandom, $urandom};
        fu_res = W'($urandom);
        cbh_a = {$urandom, $urandom}; cbh_b = {$urandom, $urandom};
        cbv_a = {$urandom, $urandom}; cbv_b = {$urandom, $urandom};
    endtask

    task automatic shift_word(input logic [19:0] w);
        for (int b = 19; b >= 0; b--) begin
            @(negedge clk);
            cfg_en = 1'b1; cfg_bit = w[b];
        end
        @(negedge clk);
        cfg_en = 1'b0; cfg_bit = 1'b0;
    endtask

    task automatic commit_now();
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
    endtask

    // Called at a negedge with the routing word already active.
    task automatic check_routing(input logic [19:0] w, input string tag);
        logic [VW-1:0] ha, hb, va, vb;
        logic [W-1:0]  fr;
        drive_data();
        #1;
        for (int t = 0; t < 2; t++) begin
            chk({tag, " R5 east"},  trk(sb_e_o, t), exp_east(t, int'(w[2*t +: 2])));
            chk({tag, " R6 north"}, trk(sb_n_o, t), exp_north(t, int'(w[4 + 2*t +: 2])));
        end
        ha = cbh_a; hb = cbh_b; va = cbv_a; vb = cbv_b; fr = fu_res;
        @(negedge clk);
        chk({tag, " R7 h fu0"}, trk(cbh_fu, 0), exp_fu(ha, hb, int'(w[9:8])));
        chk({tag, " R7 h fu1"}, trk(cbh_fu, 1), exp_fu(ha, hb, int'(w[11:10])));
        chk({tag, " R7 v fu0"}, trk(cbv_fu, 0), exp_fu(va, vb, int'(w[15:14])));
        chk({tag, " R7 v fu1"}, trk(cbv_fu, 1), exp_fu(va, vb, int'(w[17:16])));
        chk({tag, " R8 h trk0"}, trk(cbh_trk, 0), w[12] ? fr : trk(ha, 0));
        chk({tag, " R8 h trk1"}, trk(cbh_trk, 1), w[13] ? fr : trk(ha, 1));
        chk({tag, " R8 v trk0"}, trk(cbv_trk, 0), w[18] ? fr : trk(va, 0));
        chk({tag, " R8 v trk1"}, trk(cbv_trk, 1), w[19] ? fr : trk(va, 1));
    endtask

    initial begin
        logic [19:0] wa, wb;
        drive_data();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: outputs cleared out of reset, switch box on select 0
        chk("R9 reset cbh_fu", cbh_fu[W-1:0], '0);
        chk("R9 reset cbv_trk", cbv_trk[W-1:0], '0);
        check_routing(20'h0, "R9 reset-cfg");

        // R1 R4 sweep of many configurations
        for (int k = 0; k < 256; k++) begin
            wa = {6'((k * 7 + 3) & 63), 6'(k & 63), 8'(k)};
            shift_word(wa);
            commit_now();
            check_routing(wa, "R1 R4 sweep");
        end

        // R2: shift a new word without commit, routing still follows old word
        wa = 20'hA5C3E;
        shift_word(wa);
        commit_now();
        wb = ~wa;
        shift_word(wb);
        check_routing(wa, "R2 uncommitted");

        // R3: commit and shift on the same edge take the pre-shift word
        cfg_en = 1'b1; cfg_bit = 1'b1; cfg_commit = 1'b1;
        @(negedge clk);
        cfg_en = 1'b0; cfg_commit = 1'b0; cfg_bit = 1'b0;
        check_routing(wb, "R3 same-edge");

        // R9: reset mid-run clears registers and both config words
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 mid cbh_fu0", trk(cbh_fu, 0), '0);
        chk("R9 mid cbv_trk1", trk(cbv_trk, 1), '0);
        check_routing(20'h0, "R9 active-cleared");
        commit_now();
        check_routing(20'h0, "R9 stage-cleared");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule